// File: doc/BRIEF.md
# Shift-Register Return-Address Stack

This block keeps the return addresses for subroutine calls and interrupt entry in a small processor core. A call or an interrupt entry pushes the address to resume at. A return pops the most recent address, which the core then loads into its program counter. The block does not decode instructions, hold the program counter or arbitrate interrupts. It only stores and orders the return addresses.

There is no stack pointer. The storage is a chain of levels, and every level moves together on each push or pop. Level 0 is the top and the deepest level is the bottom. The top level is driven straight onto the pop data output, so a return can use it in the same cycle it is requested. When calls nest deeper than the chain, the deepest address falls off the end and is lost without any fault being raised. When more returns arrive than there were calls, the deepest level is copied upward and keeps its old value, so the extra returns give stale addresses instead of zero.

Top module: `rsk_stack`

## Requirements
- R1: While rst_ni is low, every level is cleared to zero, and pop_addr_o reads 0 once reset is released.
- R2: pop_addr_o always equals the current contents of level 0, with no clock delay. It is valid in the same cycle that pop_i is raised.
- R3: On a clock edge with push_i high, push_addr_i is written into level 0. At the same edge each level i moves to level i+1.
- R4: On a clock edge with pop_i high and push_i low, each level i+1 moves to level i. Returns therefore come back in last-in, first-out order.
- R5: With the default depth of 3, a fourth push without an intervening pop throws away the oldest address. The following three pops return the three newest addresses, newest first. No error indication of any kind exists.
- R6: A pop leaves the deepest level unchanged. Pops beyond the number of stored entries keep returning the value last held in the deepest level, not zero.
- R7: When push_i and pop_i are both high on the same edge, only the push takes place and the pop is ignored. Afterwards level 0 holds push_addr_i and level 1 holds the previous top.
- R8: On an edge with neither push_i nor pop_i high, all levels keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears all levels |
| push_i | input | 1 | Push request (call or interrupt entry) |
| push_addr_i | input | ADDR_W (10) | Return address to push |
| pop_i | input | 1 | Pop request (return) |
| pop_addr_o | output | ADDR_W (10) | Current top level, the address a pop returns |

## Verification
The bound checker checks the per-cycle rules on every edge:
- how each level moves on a push;
- how the levels shift up on a pop, with the deepest level held;
- that push wins over a simultaneous pop;
- that the levels hold when there is no request.

Only the bench scenarios show the effects over whole sequences. These are the LIFO order of nested calls, the loss of the oldest address after a fourth push, and the stale values that appear after draining past empty. They are also the only place where these results are seen purely at the ports.

// File: rtl/rsk_pkg.sv
package rsk_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } rsk_op_e;
endpackage

// File: rtl/rsk_ctrl.sv
module rsk_ctrl
  import rsk_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  output rsk_op_e op_o
);
  // push has priority over a simultaneous pop
  always_comb begin
    if (push_i)     op_o = OP_PUSH;
    else if (pop_i) op_o = OP_POP;
    else            op_o = OP_HOLD;
  end
endmodule

// File: rtl/rsk_level.sv
module rsk_level
  import rsk_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter bit          IS_LAST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rsk_op_e           op_i,
  input  logic [ADDR_W-1:0] above_i,
  input  logic [ADDR_W-1:0] below_i,
  output logic [ADDR_W-1:0] q_o
);
  logic [ADDR_W-1:0] d;

  always_comb begin
    unique case (op_i)
      OP_PUSH: d = above_i;
      OP_POP:  d = IS_LAST ? q_o : below_i;
      default: d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end
endmodule

// File: rtl/rsk_stack.sv
module rsk_stack
  import rsk_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pop_addr_o
);
  localparam int unsigned LAST = DEPTH - 1;

  rsk_op_e op;
  logic [DEPTH-1:0][ADDR_W-1:0] lvl_q;

  rsk_ctrl u_ctrl (
    .push_i (push_i),
    .pop_i  (pop_i),
    .op_o   (op)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [ADDR_W-1:0] above, below;
    if (i == 0) begin : g_top
      assign above = push_addr_i;
    end else begin : g_mid
      assign above = lvl_q[i-1];
    end
    if (i == LAST) begin : g_bot
      assign below = lvl_q[i];
    end else begin : g_nbot
      assign below = lvl_q[i+1];
    end
    rsk_level #(
      .ADDR_W  (ADDR_W),
      .IS_LAST (i == LAST)
    ) u_level (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .op_i    (op),
      .above_i (above),
      .below_i (below),
      .q_o     (lvl_q[i])
    );
  end

  assign pop_addr_o = lvl_q[0];
endmodule

// File: rtl/rsk_stack_chk.sv
module rsk_stack_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DEPTH  = 3
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         push_i,
  input logic [ADDR_W-1:0]            push_addr_i,
  input logic                         pop_i,
  input logic [ADDR_W-1:0]            pop_addr_o,
  input logic [DEPTH-1:0][ADDR_W-1:0] lvl_q
);
  a_r2_top_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_addr_o == lvl_q[0]);

  // R3 and R7: push wins, new address lands on top
  a_r3_push_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> pop_addr_o == $past(push_addr_i));

  a_r7_push_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> lvl_q[1] == $past(lvl_q[0]));

  for (genvar i = 1; i < DEPTH; i++) begin : g_push
    a_r3_push_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i |=> lvl_q[i] == $past(lvl_q[i-1]));
  end

  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_pop
    a_r4_pop_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && !push_i) |=> lvl_q[i] == $past(lvl_q[i+1]));
  end

  a_r6_pop_keeps_deepest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> $stable(lvl_q[DEPTH-1]));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i && !push_i) |=> $stable(lvl_q));
endmodule

bind rsk_stack rsk_stack_chk #(
  .ADDR_W (ADDR_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .push_addr_i (push_addr_i),
  .pop_i       (pop_i),
  .pop_addr_o  (pop_addr_o),
  .lvl_q       (lvl_q)
);

// File: tb/rsk_stack_tb_top.sv
module rsk_stack_tb_top;
  localparam int unsigned ADDR_W = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic              push_i = 1'b0;
  logic              pop_i = 1'b0;
  logic [ADDR_W-1:0] push_addr_i = '0;
  logic [ADDR_W-1:0] pop_addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [ADDR_W-1:0] m [3];

  always #5 clk_i = ~clk_i;

  rsk_stack #(.ADDR_W(ADDR_W), .DEPTH(3)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_addr_i (push_addr_i),
    .pop_i       (pop_i),
    .pop_addr_o  (pop_addr_o)
  );

  task automatic check(string req, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, clock in at posedge, release inputs
  task automatic step(bit psh, bit pp, logic [ADDR_W-1:0] a);
    @(negedge clk_i);
    push_i = psh; pop_i = pp; push_addr_i = a;
    @(posedge clk_i);
    #1;
    push_i = 1'b0; pop_i = 1'b0;
    if (psh) begin
      m[2] = m[1]; m[1] = m[0]; m[0] = a;
    end else if (pp) begin
      m[0] = m[1]; m[1] = m[2];
    end
  endtask

  task automatic do_reset();
    #3 rst_ni = 1'b0;
    #20 rst_ni = 1'b1;
    m[0] = '0; m[1] = '0; m[2] = '0;
    @(negedge clk_i);
    check("R1 reset top", pop_addr_o, '0);
  endtask

  task automatic pop_check(string req, logic [ADDR_W-1:0] exp);
    @(negedge clk_i);
    pop_i = 1'b1;
    #1 check("R2 same-cycle pop data", pop_addr_o, exp);
    @(posedge clk_i);
    #1 pop_i = 1'b0;
    m[0] = m[1]; m[1] = m[2];
    @(negedge clk_i);
    check(req, pop_addr_o, m[0]);
  endtask

  task automatic t_reset_deep();
    step(1, 0, 10'd7); step(1, 0, 10'd8); step(1, 0, 10'd9);
    do_reset();
    pop_check("R1 level1 cleared", 10'd0);
    pop_check("R1 level2 cleared", 10'd0);
  endtask

  task automatic t_nested();
    step(1, 0, 10'h101); check("R3 push top", pop_addr_o, 10'h101);
    step(1, 0, 10'h202); check("R3 push top", pop_addr_o, 10'h202);
    pop_check("R4 pop order", 10'h202);
    step(1, 0, 10'h3FF); check("R3 push top", pop_addr_o, 10'h3FF);
    pop_check("R4 pop order", 10'h3FF);
    pop_check("R4 pop order", 10'h101);
  endtask

  task automatic t_overflow();
    do_reset();
    step(1, 0, 10'd1); step(1, 0, 10'd2); step(1, 0, 10'd3); step(1, 0, 10'd4);
    check("R5 top after overflow", pop_addr_o, 10'd4);
    pop_check("R5 second newest", 10'd4);
    check("R5 model top", pop_addr_o, 10'd3);
    pop_check("R5 third newest", 10'd3);
    check("R5 oldest dropped", pop_addr_o, 10'd2);
  endtask

  task automatic t_underflow();
    do_reset();
    step(1, 0, 10'h0A); step(1, 0, 10'h0B); step(1, 0, 10'h0C);
    pop_check("R6 drain", 10'h0C);
    pop_check("R6 drain", 10'h0B);
    pop_check("R6 stale deepest", 10'h0A);
    check("R6 past empty not zero", pop_addr_o, 10'h0A);
    pop_check("R6 stale again", 10'h0A);
  endtask

  task automatic t_simul();
    do_reset();
    step(1, 0, 10'h055); step(1, 0, 10'h066);
    step(1, 1, 10'h077);
    check("R7 push wins top", pop_addr_o, 10'h077);
    pop_check("R7 previous top at level1", 10'h077);
    check("R7 level1 content", pop_addr_o, 10'h066);
    pop_check("R7 level2 content", 10'h066);
    check("R7 deepest", pop_addr_o, 10'h055);
  endtask

  task automatic t_idle();
    do_reset();
    step(1, 0, 10'h111); step(1, 0, 10'h222);
    for (int i = 0; i < 5; i++) step(0, 0, 10'h3AB);
    check("R8 idle top held", pop_addr_o, 10'h222);
    pop_check("R8 idle level1 held", 10'h222);
    check("R8 level1 value", pop_addr_o, 10'h111);
  endtask

  initial begin
    m[0] = '0; m[1] = '0; m[2] = '0;
    do_reset();
    t_reset_deep();
    t_nested();
    t_overflow();
    t_underflow();
    t_simul();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule